// File: doc/BRIEF.md
# Caching-Status Invalidation Filter

This block sits beside a node's copy of a replicated shared memory and decides whether an update arriving from a remote node has to invalidate a line in the local processor cache. It keeps one status bit per memory block. The bit records that the local processor may hold the block in its cache. A local read marks the block as possibly cached. A remote write to a marked block clears the mark and queues one invalidation request for that block. A remote write to an unmarked block is accepted without any request, so the cache only sees invalidations for blocks it may actually hold.

Queued invalidations leave through a valid/ready output that carries the block index. A remote write that needs an invalidation while that queue is full is held off with a ready signal. Remote writes that need no invalidation are never held off. The block index is the upper part of the address. The block count, block size and queue depth are parameters, and the block count and block size must be powers of two.

Top module: `cs_inv_filter`

## Requirements
- R1: Reset, whether at power-up or during operation, clears every status bit and empties the queue, so `inv_valid` is 0 and a later remote write to any block produces no invalidation.
- R2: A local read (`rd_valid` high) at any byte of a block sets that block's bit. The block index is `addr[ADDR_W-1:OFF_W]`, where OFF_W = log2(BLOCK_BYTES), so the offset bits have no effect.
- R3: A remote write to a block whose bit is clear is accepted (`wr_ready` high) and queues no invalidation.
- R4: A remote write accepted for a block whose bit is set queues exactly one invalidation carrying that block index and clears the bit. A second write to the same block then queues nothing.
- R5: When a local read and an accepted remote write name the same block in one cycle, the write is judged on the bit as it stood before that cycle, and the bit is set afterwards.
- R6: An invalidation becomes visible on `inv_valid`/`inv_block` in the cycle after its write is accepted. Requests leave in acceptance order. While `inv_ready` is low, `inv_valid` stays high and `inv_block` does not change. An entry is removed on `inv_valid && inv_ready`.
- R7: `wr_ready` is low only when the addressed block's bit is set and the queue holds QUEUE_DEPTH entries. A removal in the same cycle does not raise it. A full queue never holds off writes to blocks whose bit is clear.
- R8: A held-off remote write changes no bit and no queue entry, and it is accepted once space frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Local read of a shared location this cycle |
| rd_addr | input | ADDR_W | Byte address of the local read |
| wr_valid | input | 1 | Remote write offered this cycle |
| wr_addr | input | ADDR_W | Byte address of the remote write |
| wr_ready | output | 1 | Remote write is taken at this edge |
| inv_valid | output | 1 | An invalidation request is pending |
| inv_block | output | IDX_W | Block index of the pending invalidation |
| inv_ready | input | 1 | Cache accepts the pending invalidation |

## Verification
The vector table runs remote writes to unread blocks, to freshly read blocks, and twice in a row to the same block. These separate a filter that drops everything, one that invalidates everything, and one that forgets to clear the bit. Reads and writes that hit the same block in the same cycle show whether the write sees the old bit and whether the read survives. Filling the queue while a write to a marked block waits, with and without a removal in the same cycle, together with a write to an unmarked block during the stall, tells a correct hold-off apart from a stall that is too broad or that bypasses. Directed tests use a nonzero byte offset in the top block and a reset in the middle of operation.

// File: rtl/csf_pkg.sv
package csf_pkg;

    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_FILTER = 2'd1,
        WR_INVAL  = 2'd2,
        WR_STALL  = 2'd3
    } wr_outcome_e;

endpackage

// File: rtl/csf_block_index.sv
module csf_block_index #(
    parameter int ADDR_W = 10,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        idx = IDX_W'(addr >> OFF_W);
    end
endmodule

// File: rtl/csf_status_array.sv
module csf_status_array #(
    parameter int BLOCK_COUNT = 64,
    parameter int IDX_W       = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_en,
    input  logic [IDX_W-1:0]       clr_idx,
    input  logic                   set_en,
    input  logic [IDX_W-1:0]       set_idx,
    output logic [BLOCK_COUNT-1:0] bits
);
    typedef struct packed {
        logic [BLOCK_COUNT-1:0] mark;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clearing first, then setting: a read in the same cycle wins
        if (clr_en) st_d.mark[clr_idx] = 1'b0;
        if (set_en) st_d.mark[set_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits = st_q.mark;
endmodule

// File: rtl/csf_inv_queue.sv
module csf_inv_queue #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 6,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              not_empty,
    output logic              full,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] slot;
        logic [PTR_W-1:0]             head;
        logic [PTR_W-1:0]             tail;
        logic [CNT_W-1:0]             used;
    } state_t;

    state_t st_d, st_q;
    logic   do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop  && (st_q.used != '0);
        do_push = push && (st_q.used != CNT_W'(DEPTH));
        if (do_push) begin
            st_d.slot[st_q.tail] = push_data;
            st_d.tail = (st_q.tail == PTR_W'(DEPTH - 1)) ? '0 : st_q.tail + 1'b1;
        end
        if (do_pop) begin
            st_d.head = (st_q.head == PTR_W'(DEPTH - 1)) ? '0 : st_q.head + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.used = st_q.used + 1'b1;
            2'b01:   st_d.used = st_q.used - 1'b1;
            default: st_d.used = st_q.used;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign not_empty = (st_q.used != '0);
    assign full      = (st_q.used == CNT_W'(DEPTH));
    assign head_data = st_q.slot[st_q.head];
    assign count     = st_q.used;
endmodule

// File: rtl/cs_inv_filter.sv
module cs_inv_filter
    import csf_pkg::*;
#(
    parameter int BLOCK_COUNT = 64,
    parameter int BLOCK_BYTES = 16,
    parameter int QUEUE_DEPTH = 4,
    parameter int IDX_W       = $clog2(BLOCK_COUNT),
    parameter int ADDR_W      = $clog2(BLOCK_COUNT) + $clog2(BLOCK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_ready,
    output logic              inv_valid,
    output logic [IDX_W-1:0]  inv_block,
    input  logic              inv_ready
);
    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

    logic [IDX_W-1:0]       rd_idx, wr_idx;
    logic [BLOCK_COUNT-1:0] status_bits;
    logic                   wr_hit;
    logic                   q_full;
    logic [CNT_W-1:0]       q_count;
    wr_outcome_e            outcome;
    logic                   take_inv;

    csf_block_index #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_rd_index (
        .addr (rd_addr),
        .idx  (rd_idx)
    );

    csf_block_index #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_wr_index (
        .addr (wr_addr),
        .idx  (wr_idx)
    );

    assign wr_hit = status_bits[wr_idx];

    always_comb begin
        if (!wr_valid)    outcome = WR_NONE;
        else if (!wr_hit) outcome = WR_FILTER;
        else if (q_full)  outcome = WR_STALL;
        else              outcome = WR_INVAL;
        take_inv = (outcome == WR_INVAL);
        wr_ready = !(wr_hit && q_full);
    end

    csf_status_array #(.BLOCK_COUNT(BLOCK_COUNT), .IDX_W(IDX_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (take_inv),
        .clr_idx (wr_idx),
        .set_en  (rd_valid),
        .set_idx (rd_idx),
        .bits    (status_bits)
    );

    csf_inv_queue #(.DEPTH(QUEUE_DEPTH), .DATA_W(IDX_W), .CNT_W(CNT_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take_inv),
        .push_data (wr_idx),
        .pop       (inv_ready),
        .not_empty (inv_valid),
        .full      (q_full),
        .head_data (inv_block),
        .count     (q_count)
    );
endmodule

// File: rtl/cs_inv_filter_chk.sv
module cs_inv_filter_chk #(
    parameter int BLOCK_COUNT = 64,
    parameter int QUEUE_DEPTH = 4,
    parameter int IDX_W       = 6,
    parameter int CNT_W       = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rd_valid,
    input logic [IDX_W-1:0]       rd_idx,
    input logic                   wr_valid,
    input logic [IDX_W-1:0]       wr_idx,
    input logic                   wr_ready,
    input logic                   wr_hit,
    input logic                   inv_valid,
    input logic [IDX_W-1:0]       inv_block,
    input logic                   inv_ready,
    input logic [BLOCK_COUNT-1:0] status_bits,
    input logic [CNT_W-1:0]       q_count
);
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !inv_valid);

    a_r2_read_marks: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> status_bits[$past(rd_idx)]);

    a_r4_hit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_hit && !(rd_valid && rd_idx == wr_idx))
        |=> !status_bits[$past(wr_idx)]);

    a_r4_hit_queues: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_hit) |=> inv_valid);

    a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_block)));

    a_r7_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> (wr_hit && q_count == CNT_W'(QUEUE_DEPTH)));

    a_r8_stall_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready && !(inv_valid && inv_ready))
        |=> (q_count == $past(q_count)));
endmodule

bind cs_inv_filter cs_inv_filter_chk #(
    .BLOCK_COUNT (BLOCK_COUNT),
    .QUEUE_DEPTH (QUEUE_DEPTH),
    .IDX_W       (IDX_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid    (rd_valid),
    .rd_idx      (rd_idx),
    .wr_valid    (wr_valid),
    .wr_idx      (wr_idx),
    .wr_ready    (wr_ready),
    .wr_hit      (wr_hit),
    .inv_valid   (inv_valid),
    .inv_block   (inv_block),
    .inv_ready   (inv_ready),
    .status_bits (status_bits),
    .q_count     (q_count)
);

// File: tb/sim_cs_inv_filter.sv
module sim_cs_inv_filter;
    localparam int IDX_W  = 6;
    localparam int OFF_W  = 4;
    localparam int ADDR_W = IDX_W + OFF_W;
    localparam int NVEC   = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_valid = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic              wr_ready;
    logic              inv_valid;
    logic [IDX_W-1:0]  inv_block;
    logic              inv_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cs_inv_filter u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_ready(wr_ready),
        .inv_valid(inv_valid), .inv_block(inv_block), .inv_ready(inv_ready)
    );

    typedef struct packed {
        logic             rv;
        logic [IDX_W-1:0] rb;
        logic [OFF_W-1:0] ro;
        logic             wv;
        logic [IDX_W-1:0] wb;
        logic             ir;
        logic             ew;
        logic             ei;
        logic [IDX_W-1:0] eb;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 6'd3,  4'd0,  1'b1, 6'd5,  1'b0, 1'b1, 1'b0, 6'd0 },
        '{1'b0, 6'd0,  4'd0,  1'b1, 6'd3,  1'b0, 1'b1, 1'b0, 6'd0 },
        '{1'b0, 6'd0,  4'd0,  1'b1, 6'd3,  1'b0, 1'b1, 1'b1, 6'd3 },
        '{1'b1, 6'd7,  4'd9,  1'b1, 6'd7,  1'b0, 1'b1, 1'b1, 6'd3 },
        '{1'b0, 6'd0,  4'd0,  1'b1, 6'd7,  1'b0, 1'b1, 1'b1, 6'd3 },
        '{1'b1, 6'd10, 4'd15, 1'b0, 6'd0,  1'b0, 1'b1, 1'b1, 6'd3 },
        '{1'b1, 6'd10, 4'd1,  1'b1, 6'd10, 1'b0, 1'b1, 1'b1, 6'd3 },
        '{1'b0, 6'd0,  4'd0,  1'b1, 6'd10, 1'b0, 1'b1, 1'b1, 6'd3 },
        '{1'b1, 6'd12, 4'd4,  1'b0, 6'd12, 1'b0, 1'b1, 1'b1, 6'd3 },
        '{1'b0, 6'd0,  4'd0,  1'b1, 6'd12, 1'b0, 1'b0, 1'b1, 6'd3 },
        '{1'b0, 6'd0,  4'd0,  1'b1, 6'd12, 1'b1, 1'b0, 1'b1, 6'd3 },
        '{1'b0, 6'd0,  4'd0,  1'b1, 6'd12, 1'b0, 1'b1, 1'b1, 6'd7 },
        '{1'b0, 6'd0,  4'd0,  1'b1, 6'd2,  1'b1, 1'b1, 1'b1, 6'd7 },
        '{1'b0, 6'd0,  4'd0,  1'b0, 6'd0,  1'b1, 1'b1, 1'b1, 6'd10},
        '{1'b0, 6'd0,  4'd0,  1'b0, 6'd0,  1'b1, 1'b1, 1'b1, 6'd10},
        '{1'b0, 6'd0,  4'd0,  1'b0, 6'd0,  1'b1, 1'b1, 1'b1, 6'd12},
        '{1'b0, 6'd0,  4'd0,  1'b1, 6'd12, 1'b0, 1'b1, 1'b0, 6'd0 }
    };

    localparam string TAG [NVEC] = '{
        "R3", "R4", "R4", "R5", "R5", "R2", "R5", "R5", "R2",
        "R7", "R7", "R8", "R7", "R6", "R6", "R6", "R4"
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive at the falling edge, sample 2 ns later; the next rising edge commits
    task automatic cyc(input logic rv, input logic [ADDR_W-1:0] ra,
                       input logic wv, input logic [ADDR_W-1:0] wa, input logic ir);
        @(negedge clk);
        rd_valid = rv; rd_addr = ra;
        wr_valid = wv; wr_addr = wa;
        inv_ready = ir;
        #2;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: state while in reset
        #5;
        check("R1", "inv_valid in reset", int'(inv_valid), 0);
        check("R1", "wr_ready in reset", int'(wr_ready), 1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            cyc(VEC[i].rv, {VEC[i].rb, VEC[i].ro}, VEC[i].wv, {VEC[i].wb, 4'd0}, VEC[i].ir);
            check(TAG[i], $sformatf("step %0d wr_ready", i), int'(wr_ready), int'(VEC[i].ew));
            check(TAG[i], $sformatf("step %0d inv_valid", i), int'(inv_valid), int'(VEC[i].ei));
            if (VEC[i].ei)
                check(TAG[i], $sformatf("step %0d inv_block", i), int'(inv_block), int'(VEC[i].eb));
        end

        // R2: top block, nonzero offset, then a write at offset 0
        cyc(1'b1, {6'd63, 4'd15}, 1'b0, '0, 1'b0);
        cyc(1'b0, '0, 1'b1, {6'd63, 4'd0}, 1'b0);
        check("R2", "top block write ready", int'(wr_ready), 1);
        cyc(1'b0, '0, 1'b0, '0, 1'b1);
        check("R2", "top block inv_valid", int'(inv_valid), 1);
        check("R2", "top block inv_block", int'(inv_block), 63);
        cyc(1'b0, '0, 1'b0, '0, 1'b0);
        check("R6", "empty after removal", int'(inv_valid), 0);

        // R1: reset in the middle of operation clears a set bit and the queue
        cyc(1'b1, {6'd20, 4'd3}, 1'b0, '0, 1'b0);
        cyc(1'b1, {6'd21, 4'd0}, 1'b1, {6'd20, 4'd0}, 1'b0);
        cyc(1'b0, '0, 1'b0, '0, 1'b0);
        check("R4", "queued before reset", int'(inv_valid), 1);
        rst_n = 1'b0;
        #2;
        check("R1", "queue emptied by reset", int'(inv_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, '0, 1'b1, {6'd21, 4'd0}, 1'b0);
        check("R1", "write after reset ready", int'(wr_ready), 1);
        cyc(1'b0, '0, 1'b0, '0, 1'b0);
        check("R1", "no inv after reset", int'(inv_valid), 0);

        done = 1'b1;
        finish_run();
    end
endmodule